// File: doc/BRIEF.md
# Condition-Tested Vector Truncation Sequencer

The block steps through the element results of one vector operation, one element per cycle. For each element it builds a four-bit condition field from the signed result. It then tests one chosen bit of that field against an invert flag. While every element passes, each result is allowed through to the register file. The first element that fails ends the loop. The failing element and everything after it are discarded, and a new vector length is reported.

The new length is decided only by the data. It can exclude the failing element or include it, and it is zero when the very first element fails. A compare-only mode stores the condition field and never writes a result. The walk can run from the lowest element upward or from the highest element downward.

A start pulse latches the length and the mode bits. Elements then arrive on a valid/ready handshake, and a single-cycle done strobe returns the final length.

Top module: `ffirst_seq`

## Requirements
- R1: With `mode_rev`=0, the k-th accepted element (counting from 0) is reported on `elem_idx` as k.
- R2: With `mode_rev`=1, the k-th accepted element is reported as VL-1-k.
- R3: The condition field `cr_field` is {lt,gt,eq,so} on bits 3..0. lt is set for a negative result, gt for a positive one and eq for zero, and so is always 0. `cr_we` pulses for every accepted element when `mode_rc`=1 or `mode_rc1`=1.
- R4: `mode_sel` values 0, 1, 2 and 3 pick lt, gt, eq and so. With `mode_inv`=0 an element passes when the picked bit is 1. With `mode_inv`=1 it passes when that bit is 0.
- R5: A passing element raises `res_we`. A failing element does not, and no later element is accepted (`elem_ready` drops).
- R6: On a failure at position k, the new VL is k when `mode_incl`=0 and k+1 when `mode_incl`=1.
- R7: When `mode_rc`=1, `mode_incl` has no effect and the new VL is k.
- R8: A failure at the first processed element yields a new VL of 0.
- R9: When no element fails, the reported VL equals the starting VL. The reported VL never exceeds the starting VL.
- R10: With `mode_rc1`=1, the eq bit is tested whatever `mode_sel` holds, the condition field is written, and `res_we` never rises.
- R11: `elem_ready` is high only while a vector is running. `done` pulses for one cycle, in the cycle after the final or failing element is accepted.
- R12: A start with VL=0 gives `done` in the next cycle with `vl_out`=0, and nothing is written.
- R13: After reset, `elem_ready`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a vector; taken only while idle |
| vl_in | input | VL_W | Starting vector length |
| mode_sel | input | 2 | Tested bit: 0 lt, 1 gt, 2 eq, 3 so |
| mode_inv | input | 1 | Invert the test |
| mode_incl | input | 1 | Count the failing element in the new length |
| mode_rc1 | input | 1 | Compare-only: test eq, store field, drop result |
| mode_rc | input | 1 | Store condition fields; disables inclusive count |
| mode_rev | input | 1 | Walk from VL-1 down to 0 |
| busy | output | 1 | A vector is in progress |
| elem_valid | input | 1 | Element result present |
| elem_data | input | DATA_W | Signed element result |
| elem_ready | output | 1 | Element can be taken |
| elem_idx | output | VL_W | Element number of the accepted element |
| cr_we | output | 1 | Store `cr_field` for `elem_idx` |
| cr_field | output | 4 | Condition field {lt,gt,eq,so} |
| res_we | output | 1 | Store the result for `elem_idx` |
| done | output | 1 | One-cycle completion strobe |
| vl_out | output | VL_W | New vector length, valid with `done` |

## Verification
On every cycle, the assertions check these properties: the condition field keeps exactly one of lt/gt/eq set with so clear, writes occur only on accepted elements, element numbers stay below the starting length, and the reported length never grows. They also check that done follows activity and that the end of a run always brings done. The exact cut point needs the bench's scenarios: exclusive versus inclusive counting, the override by the condition-store flag, a zero-length result, the reverse walk and the compare-only mode. In those scenarios a behavioural model compares every output cycle by cycle.

// File: rtl/ffirst_pkg.sv
package ffirst_pkg;
  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } seq_state_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       inv;
    logic       incl;
    logic       rc1;
    logic       rc;
    logic       rev;
  } ff_mode_t;

  localparam int unsigned CR_LT = 3;
  localparam int unsigned CR_GT = 2;
  localparam int unsigned CR_EQ = 1;
  localparam int unsigned CR_SO = 0;
endpackage

// File: rtl/ffirst_rst_sync.sv
module ffirst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ffirst_crtest.sv
module ffirst_crtest
  import ffirst_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] data,
  input  ff_mode_t          mode,
  output logic [3:0]        field,
  output logic              pass
);
  logic neg, zero, tbit;

  always_comb begin
    neg   = data[DATA_W-1];
    zero  = (data == '0);
    field = '0;
    field[CR_LT] = neg;
    field[CR_GT] = !neg && !zero;
    field[CR_EQ] = zero;
    field[CR_SO] = 1'b0;
    if (mode.rc1) begin
      tbit = field[CR_EQ];
    end else begin
      unique case (mode.sel)
        2'd0:    tbit = field[CR_LT];
        2'd1:    tbit = field[CR_GT];
        2'd2:    tbit = field[CR_EQ];
        default: tbit = field[CR_SO];
      endcase
    end
    pass = (tbit != mode.inv);
  end
endmodule

// File: rtl/ffirst_ctrl.sv
module ffirst_ctrl
  import ffirst_pkg::*;
#(
  parameter int unsigned VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vl_in,
  input  logic            acc,
  input  logic            pass,
  input  logic            incl,
  output logic            running,
  output logic            take_mode,
  output logic [VL_W-1:0] pos,
  output logic [VL_W-1:0] vl_cur,
  output logic            done,
  output logic [VL_W-1:0] vl_out
);
  localparam logic [VL_W-1:0] ONE = VL_W'(1);

  seq_state_e      state_q, state_d;
  logic [VL_W-1:0] pos_q, pos_d, vl_q, vl_d, out_q, out_d;
  logic            done_q, done_d, pos_ce, vl_ce, out_ce;

  always_comb begin
    state_d   = state_q;
    pos_d     = pos_q;
    vl_d      = vl_q;
    out_d     = out_q;
    done_d    = 1'b0;
    pos_ce    = 1'b0;
    vl_ce     = 1'b0;
    out_ce    = 1'b0;
    take_mode = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          take_mode = 1'b1;
          if (vl_in == '0) begin
            done_d = 1'b1;
            out_d  = '0;
            out_ce = 1'b1;
          end else begin
            state_d = ST_RUN;
            vl_d    = vl_in;
            vl_ce   = 1'b1;
            pos_d   = '0;
            pos_ce  = 1'b1;
          end
        end
      end
      default: begin
        if (acc) begin
          if (!pass) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            out_d   = pos_q + (incl ? ONE : '0);
            out_ce  = 1'b1;
          end else if (pos_q == vl_q - ONE) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            out_d   = vl_q;
            out_ce  = 1'b1;
          end else begin
            pos_d  = pos_q + ONE;
            pos_ce = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else if (pos_ce) pos_q <= pos_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vl_q <= '0;
    else if (vl_ce) vl_q <= vl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (out_ce) out_q <= out_d;
  end

  assign running = (state_q == ST_RUN);
  assign pos     = pos_q;
  assign vl_cur  = vl_q;
  assign done    = done_q;
  assign vl_out  = out_q;
endmodule

// File: rtl/ffirst_seq.sv
module ffirst_seq
  import ffirst_pkg::*;
#(
  parameter int unsigned VL_W   = 7,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl_in,
  input  logic [1:0]        mode_sel,
  input  logic              mode_inv,
  input  logic              mode_incl,
  input  logic              mode_rc1,
  input  logic              mode_rc,
  input  logic              mode_rev,
  output logic              busy,
  input  logic              elem_valid,
  input  logic [DATA_W-1:0] elem_data,
  output logic              elem_ready,
  output logic [VL_W-1:0]   elem_idx,
  output logic              cr_we,
  output logic [3:0]        cr_field,
  output logic              res_we,
  output logic              done,
  output logic [VL_W-1:0]   vl_out
);
  logic            rst_sync_n, running, take_mode, acc, pass;
  logic [VL_W-1:0] pos, vl_cur;
  ff_mode_t        mode_q, mode_in;

  ffirst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign mode_in = '{sel: mode_sel, inv: mode_inv, incl: mode_incl,
                     rc1: mode_rc1, rc: mode_rc, rev: mode_rev};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= '0;
    else if (take_mode) mode_q <= mode_in;
  end

  ffirst_crtest #(.DATA_W(DATA_W)) u_test (
    .data  (elem_data),
    .mode  (mode_q),
    .field (cr_field),
    .pass  (pass)
  );

  assign acc = elem_valid && running;

  ffirst_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .vl_in     (vl_in),
    .acc       (acc),
    .pass      (pass),
    .incl      (mode_q.incl && !mode_q.rc),
    .running   (running),
    .take_mode (take_mode),
    .pos       (pos),
    .vl_cur    (vl_cur),
    .done      (done),
    .vl_out    (vl_out)
  );

  assign busy       = running;
  assign elem_ready = running;
  assign elem_idx   = mode_q.rev ? (vl_cur - VL_W'(1) - pos) : pos;
  assign cr_we      = acc && (mode_q.rc || mode_q.rc1);
  assign res_we     = acc && pass && !mode_q.rc1;
endmodule

// File: rtl/ffirst_seq_chk.sv
module ffirst_seq_chk #(
  parameter int unsigned VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VL_W-1:0] vl_in,
  input logic            busy,
  input logic            elem_valid,
  input logic            elem_ready,
  input logic [VL_W-1:0] elem_idx,
  input logic            cr_we,
  input logic [3:0]      cr_field,
  input logic            res_we,
  input logic            done,
  input logic [VL_W-1:0] vl_out
);
  logic [VL_W-1:0] vl_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vl_cap <= '0;
    else if (start && !busy) vl_cap <= vl_in;
  end

  p_so_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> !cr_field[0]);
  p_cr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> $countones(cr_field[3:1]) == 1);
  p_we_on_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we || res_we) |-> (elem_ready && elem_valid));
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we || res_we) |-> elem_idx < vl_cap);
  p_vl_not_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vl_out <= vl_cap);
  p_done_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start)));
  p_end_gives_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind ffirst_seq ffirst_seq_chk #(.VL_W(VL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .vl_in      (vl_in),
  .busy       (busy),
  .elem_valid (elem_valid),
  .elem_ready (elem_ready),
  .elem_idx   (elem_idx),
  .cr_we      (cr_we),
  .cr_field   (cr_field),
  .res_we     (res_we),
  .done       (done),
  .vl_out     (vl_out)
);

// File: tb/ffirst_seq_tb_top.sv
module ffirst_seq_tb_top;
  localparam int VL_W = 7;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VL_W-1:0] vl_in = '0;
  logic [1:0] mode_sel = '0;
  logic mode_inv = 0, mode_incl = 0, mode_rc1 = 0, mode_rc = 0, mode_rev = 0;
  logic elem_valid = 0;
  logic [DW-1:0] elem_data = '0;
  logic busy, elem_ready, cr_we, res_we, done;
  logic [VL_W-1:0] elem_idx, vl_out;
  logic [3:0] cr_field;

  int compared = 0, mismatched = 0;

  // behavioural model state
  bit m_busy = 0, m_done = 0;
  int m_k = 0, m_vl = 0, m_out = 0;
  bit saw_done;
  int seen_vl;
  logic signed [DW-1:0] dat [8];

  always #5 clk = ~clk;

  ffirst_seq #(.VL_W(VL_W), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
    .mode_sel(mode_sel), .mode_inv(mode_inv), .mode_incl(mode_incl),
    .mode_rc1(mode_rc1), .mode_rc(mode_rc), .mode_rev(mode_rev),
    .busy(busy), .elem_valid(elem_valid), .elem_data(elem_data),
    .elem_ready(elem_ready), .elem_idx(elem_idx), .cr_we(cr_we),
    .cr_field(cr_field), .res_we(res_we), .done(done), .vl_out(vl_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: inputs already driven at negedge; compare, then advance model
  task automatic tick();
    bit acc, lt, eq, gt, tb, pass, e_cr, e_res;
    logic [3:0] fld;
    int idx;
    #2;
    acc = m_busy && elem_valid;
    lt  = elem_data[DW-1];
    eq  = (elem_data == 0);
    gt  = !lt && !eq;
    fld = {lt, gt, eq, 1'b0};
    tb  = mode_rc1 ? eq : fld[3 - mode_sel];
    pass = (tb != mode_inv);
    idx = mode_rev ? (m_vl - 1 - m_k) : m_k;
    e_cr  = acc && (mode_rc || mode_rc1);
    e_res = acc && pass && !mode_rc1;
    chk(elem_ready == m_busy, "R11 ready", elem_ready, m_busy);
    chk(busy == m_busy, "R11 busy", busy, m_busy);
    chk(done == m_done, "R11 done", done, m_done);
    chk(cr_we == e_cr, "R3 cr_we", cr_we, e_cr);
    chk(res_we == e_res, mode_rc1 ? "R10 res_we" : "R5 res_we", res_we, e_res);
    if (e_cr) chk(cr_field == fld, "R3 field", cr_field, fld);
    if (acc) chk(int'(elem_idx) == idx, mode_rev ? "R2 idx" : "R1 idx", elem_idx, idx);
    if (m_done) begin
      chk(int'(vl_out) == m_out, "R6 vl_out", vl_out, m_out);
      saw_done = 1;
      seen_vl  = vl_out;
    end
    @(posedge clk);
    m_done = 0;
    if (!m_busy && start) begin
      if (vl_in == 0) begin m_done = 1; m_out = 0; end
      else begin m_busy = 1; m_k = 0; m_vl = vl_in; end
    end else if (acc) begin
      if (!pass) begin
        m_busy = 0; m_done = 1; m_out = m_k + ((mode_incl && !mode_rc) ? 1 : 0);
      end else if (m_k == m_vl - 1) begin
        m_busy = 0; m_done = 1; m_out = m_vl;
      end else m_k++;
    end
    @(negedge clk);
  endtask

  task automatic run(input int vl, input int sel, input bit inv, input bit incl,
                     input bit rc1, input bit rc, input bit rev,
                     input int exp_vl, input string req);
    int guard;
    mode_sel = sel[1:0]; mode_inv = inv; mode_incl = incl;
    mode_rc1 = rc1; mode_rc = rc; mode_rev = rev;
    vl_in = vl[VL_W-1:0];
    start = 1; saw_done = 0;
    tick();
    start = 0;
    guard = 0;
    while (!saw_done && guard < 100) begin
      elem_valid = (guard % 3) != 1;   // occasional bubble
      elem_data  = dat[m_k % 8];
      tick();
      guard++;
    end
    elem_valid = 0;
    chk(saw_done && seen_vl == exp_vl, req, seen_vl, exp_vl);
    tick();
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(!busy && !elem_ready && !done, "R13 reset", {busy, elem_ready, done}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !elem_ready && !done, "R13 after release", {busy, elem_ready, done}, 0);

    // all negative, test lt set: no failure
    dat = '{-1, -5, -100, -2, -3, -4, -7, -8};
    run(4, 0, 0, 0, 0, 1, 0, 4, "R9 no fail keeps VL");
    // test eq clear (nonzero), zero at position 2
    dat = '{3, 5, 0, 7, 1, 1, 1, 1};
    run(5, 2, 1, 0, 0, 0, 0, 2, "R6 exclusive cut");
    run(5, 2, 1, 1, 0, 0, 0, 3, "R6 inclusive cut");
    run(5, 2, 1, 1, 0, 1, 0, 2, "R7 Rc disables inclusive");
    // first element fails
    dat = '{0, 4, 4, 4, 4, 4, 4, 4};
    run(4, 2, 1, 0, 0, 0, 0, 0, "R8 first fails gives zero");
    // reverse walk, gt test, fail at position 2
    dat = '{9, 8, -1, 6, 6, 6, 6, 6};
    run(3, 1, 0, 0, 0, 1, 1, 2, "R2 reverse cut");
    // compare-only: sel says so, but eq is tested; eq set required
    dat = '{0, 0, 4, 0, 0, 0, 0, 0};
    run(5, 3, 0, 1, 1, 0, 0, 3, "R10 compare-only tests eq");
    // so is always 0: inv=1 on so passes everything
    dat = '{1, -1, 0, 2, -2, 0, 3, 3};
    run(7, 3, 1, 0, 0, 1, 0, 7, "R4 so select inverted");
    // so with inv=0 fails immediately
    run(6, 3, 0, 1, 0, 0, 1, 1, "R4 so select fails first");
    // zero-length start
    run(0, 0, 0, 0, 0, 0, 0, 0, "R12 zero VL start");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule